// File: doc/BRIEF.md
# Blitter Address Walker

This block produces the three byte-address streams that a rectangular 2D transfer in video memory needs: one for the pattern read, one for the source read and one for the destination write. A start pulse captures a full parameter set. After that the block walks the rectangle one byte per enabled clock. Memory access, the raster-operation datapath and register decoding all sit outside the block. A consumer reads the three address outputs in every cycle where `busy_o` and `enable_i` are both high and `start_i` is low. That is also the cycle in which the walker advances.

The pattern and source streams can each repeat inside a power-of-two tile. An encoded wrap byte sets the tile width, the tile height and, for the pattern only, whether the start address is aligned to the tile. The X direction can be reversed, and so can the Y direction. All address arithmetic is carried out modulo 2^ADDR_W.

Top module: `blit_addr_walker`

## Requirements
- R1: After reset, `busy_o` and `done_o` are low and all three address outputs are zero.
- R2: One cycle after `start_i`, `busy_o` is high and `dst_addr_o` equals the captured destination base. A start pulse has priority over stepping: the addresses shown in the start cycle are not consumed.
- R3: The rectangle holds (count_x+1)×(count_y+1) steps. In the cycle after the final step, `busy_o` is low and `done_o` is high for exactly one cycle. `done_o` never rises at any other time.
- R4: While busy with `enable_i` low, all outputs hold their values.
- R5: Direction bit 0 set makes X decrement: the destination address drops by 1 per byte, and the pattern and source addresses are their bases minus their X offsets. With the bit clear, the destination rises by 1 and the reads use base plus X offset.
- R6: Direction bit 1 set makes every row step subtract the stride; clear makes it add.
- R7: At a row end, the pattern and source bases move by their offset+1. The destination moves to its row-start address ± (destination offset+1).
- R8: Wrap byte bits 2:0 select the X tile. Codes 0 and 1 keep the X offset at 0. Codes 2 to 6 mask the offset with 2^code−1. Code 7 means no X wrap. The offset increments after every byte within a row. At a row end, the source offset returns to 0 and the pattern offset returns to its initial value.
- R9: Wrap byte bit 6 clear gives a tile of 2^(bits 5:4) rows. Bit 6 set means no Y wrap. When a stream's row counter completes its tile, the source base reloads the programmed source address and the pattern base returns to its aligned start.
- R10: At start, the pattern address bits under the X mask become the initial pattern X offset and are cleared from the base. If pattern wrap bit 7 is clear and both X and Y are bounded, the starting tile row is taken from the address bits above the X field, and the base is aligned to the whole tile.
- R11: Every address output wraps modulo 2^ADDR_W, in both directions.
- R12: A start pulse while busy abandons the running rectangle and begins the new one with no `done_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture parameters and begin a rectangle |
| enable_i | input | 1 | Advance one byte this cycle |
| dir_i | input | 2 | Bit 0: X decrement, bit 1: Y decrement |
| pat_base_i | input | ADDR_W | Pattern start address |
| src_base_i | input | ADDR_W | Source start address |
| dst_base_i | input | ADDR_W | Destination start address |
| pat_off_i | input | OFF_W | Pattern row offset (stride − 1) |
| src_off_i | input | OFF_W | Source row offset (stride − 1) |
| dst_off_i | input | OFF_W | Destination row offset (stride − 1) |
| pat_wrap_i | input | 8 | Pattern wrap byte |
| src_wrap_i | input | 8 | Source wrap byte |
| count_x_i | input | CNT_W | Bytes per row minus one |
| count_y_i | input | CNT_W | Rows minus one |
| pat_addr_o | output | ADDR_W | Pattern read address |
| src_addr_o | output | ADDR_W | Source read address |
| dst_addr_o | output | ADDR_W | Destination write address |
| busy_o | output | 1 | Rectangle in progress |
| done_o | output | 1 | One-cycle pulse after the final step |

## Verification
The bench builds the walker with ADDR_W=12, OFF_W=8 and CNT_W=8. The 4 KB address space lets a descending walk that starts near zero wrap to the top of memory within a few steps. The 8-bit offsets keep row strides small enough that each tile and wrap boundary falls inside rectangles of a few dozen bytes. With these sizes, each of the tile decode codes, both alignment variants, the direction pairs, stalls and a mid-run restart can all be run as short rectangles.

// File: rtl/blit_walk_pkg.sv
package blit_walk_pkg;

  typedef struct packed {
    logic       x_open;    // no X wrap
    logic [2:0] x_log;     // log2 of X tile width
    logic       y_open;    // no Y wrap
    logic [1:0] y_log;     // log2 of Y tile height
    logic       no_align;  // skip tile alignment at start
  } wrap_cfg_t;

  function automatic wrap_cfg_t decode_wrap(input logic [2:0] x_code,
                                            input logic [2:0] y_code,
                                            input logic       skip_align);
    wrap_cfg_t c;
    c.x_open   = (x_code == 3'd7);
    c.x_log    = (x_code < 3'd2 || x_code == 3'd7) ? 3'd0 : x_code;
    c.y_open   = y_code[2];
    c.y_log    = y_code[1:0];
    c.no_align = skip_align;
    return c;
  endfunction

endpackage

// File: rtl/blit_rect_ctrl.sv
module blit_rect_ctrl #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             enable_i,
  input  logic [CNT_W-1:0] count_x_i,
  input  logic [CNT_W-1:0] count_y_i,
  output logic             step_o,
  output logic             row_end_o,
  output logic             busy_o,
  output logic             done_o
);

  logic [CNT_W-1:0] pos_x_q, pos_y_q, lim_x_q, lim_y_q;
  logic             busy_q, done_q;
  logic             last_step;

  assign step_o    = busy_q & enable_i & ~start_i;
  assign row_end_o = (pos_x_q == lim_x_q);
  assign last_step = row_end_o & (pos_y_q == lim_y_q);
  assign busy_o    = busy_q;
  assign done_o    = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_x_q <= '0;
      pos_y_q <= '0;
      lim_x_q <= '0;
      lim_y_q <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else if (start_i) begin
      pos_x_q <= '0;
      pos_y_q <= '0;
      lim_x_q <= count_x_i;
      lim_y_q <= count_y_i;
      busy_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (step_o) begin
        if (row_end_o) begin
          pos_x_q <= '0;
          if (last_step) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            pos_y_q <= pos_y_q + 1'b1;
          end
        end else begin
          pos_x_q <= pos_x_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/blit_tile_walker.sv
module blit_tile_walker
  import blit_walk_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int OFF_W  = 16,
  parameter bit ALIGN  = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic              row_end_i,
  input  logic              x_dec_i,
  input  logic              y_dec_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [7:0]        wrap_i,
  output logic [ADDR_W-1:0] addr_o
);

  wrap_cfg_t         cfg_d;
  logic [ADDR_W-1:0] xmask_d, x0_d, home_d, stride_d;
  logic [2:0]        y0_d, ymax_d;
  logic              unused_wrap;

  logic [ADDR_W-1:0] base_q, home_q, x_q, x0_q, xmask_q, stride_q;
  logic [2:0]        y_q, ymax_q;
  logic              y_open_q;
  logic              tile_row_wrap;

  assign cfg_d       = decode_wrap(wrap_i[2:0], wrap_i[6:4], wrap_i[7]);
  assign unused_wrap = wrap_i[3];
  assign xmask_d     = cfg_d.x_open ? '1 : ((ADDR_W'(1) << cfg_d.x_log) - ADDR_W'(1));
  assign ymax_d      = 3'((4'd1 << cfg_d.y_log) - 4'd1);
  assign stride_d    = ADDR_W'(off_i) + ADDR_W'(1);

  generate
    if (ALIGN) begin : g_align
      logic [ADDR_W-1:0] b1;
      logic [3:0]        tile_log;
      assign b1       = base_i & ~xmask_d;
      assign tile_log = {1'b0, cfg_d.x_log} + {2'b00, cfg_d.y_log};
      assign x0_d     = base_i & xmask_d;
      always_comb begin
        if (!cfg_d.no_align && !cfg_d.x_open && !cfg_d.y_open) begin
          y0_d   = 3'(b1 >> cfg_d.x_log) & ymax_d;
          home_d = b1 & ~((ADDR_W'(1) << tile_log) - ADDR_W'(1));
        end else begin
          y0_d   = 3'd0;
          home_d = b1;
        end
      end
    end else begin : g_plain
      logic unused_cfg;
      assign unused_cfg = cfg_d.no_align;
      assign x0_d       = '0;
      assign y0_d       = 3'd0;
      assign home_d     = base_i;
    end
  endgenerate

  assign tile_row_wrap = !y_open_q && (y_q == ymax_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q   <= '0;
      home_q   <= '0;
      x_q      <= '0;
      x0_q     <= '0;
      xmask_q  <= '0;
      stride_q <= '0;
      y_q      <= 3'd0;
      ymax_q   <= 3'd0;
      y_open_q <= 1'b1;
    end else if (load_i) begin
      base_q   <= home_d;
      home_q   <= home_d;
      x_q      <= x0_d;
      x0_q     <= x0_d;
      xmask_q  <= xmask_d;
      stride_q <= stride_d;
      y_q      <= y0_d;
      ymax_q   <= ymax_d;
      y_open_q <= cfg_d.y_open;
    end else if (step_i) begin
      if (row_end_i) begin
        x_q <= x0_q;
        if (tile_row_wrap) begin
          base_q <= home_q;
          y_q    <= 3'd0;
        end else begin
          base_q <= y_dec_i ? (base_q - stride_q) : (base_q + stride_q);
          y_q    <= y_q + 3'd1;
        end
      end else begin
        x_q <= (x_q + ADDR_W'(1)) & xmask_q;
      end
    end
  end

  assign addr_o = x_dec_i ? (base_q - x_q) : (base_q + x_q);

endmodule

// File: rtl/blit_dest_walker.sv
module blit_dest_walker #(
  parameter int ADDR_W = 21,
  parameter int OFF_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic              row_end_i,
  input  logic              x_dec_i,
  input  logic              y_dec_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [ADDR_W-1:0] addr_o
);

  logic [ADDR_W-1:0] cur_q, row_q, stride_q, next_row;

  assign next_row = y_dec_i ? (row_q - stride_q) : (row_q + stride_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q    <= '0;
      row_q    <= '0;
      stride_q <= '0;
    end else if (load_i) begin
      cur_q    <= base_i;
      row_q    <= base_i;
      stride_q <= ADDR_W'(off_i) + ADDR_W'(1);
    end else if (step_i) begin
      if (row_end_i) begin
        cur_q <= next_row;
        row_q <= next_row;
      end else begin
        cur_q <= x_dec_i ? (cur_q - ADDR_W'(1)) : (cur_q + ADDR_W'(1));
      end
    end
  end

  assign addr_o = cur_q;

endmodule

// File: rtl/blit_addr_walker.sv
module blit_addr_walker #(
  parameter int ADDR_W = 21,
  parameter int OFF_W  = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              enable_i,
  input  logic [1:0]        dir_i,
  input  logic [ADDR_W-1:0] pat_base_i,
  input  logic [ADDR_W-1:0] src_base_i,
  input  logic [ADDR_W-1:0] dst_base_i,
  input  logic [OFF_W-1:0]  pat_off_i,
  input  logic [OFF_W-1:0]  src_off_i,
  input  logic [OFF_W-1:0]  dst_off_i,
  input  logic [7:0]        pat_wrap_i,
  input  logic [7:0]        src_wrap_i,
  input  logic [CNT_W-1:0]  count_x_i,
  input  logic [CNT_W-1:0]  count_y_i,
  output logic [ADDR_W-1:0] pat_addr_o,
  output logic [ADDR_W-1:0] src_addr_o,
  output logic [ADDR_W-1:0] dst_addr_o,
  output logic              busy_o,
  output logic              done_o
);

  localparam int NUM_TILE = 2;  // 0: pattern, 1: source

  logic [1:0]        dir_q;
  logic              step, row_end;
  logic [ADDR_W-1:0] tile_base [NUM_TILE];
  logic [OFF_W-1:0]  tile_off  [NUM_TILE];
  logic [7:0]        tile_wrap [NUM_TILE];
  logic [ADDR_W-1:0] tile_addr [NUM_TILE];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      dir_q <= 2'b00;
    else if (start_i) dir_q <= dir_i;
  end

  blit_rect_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .enable_i  (enable_i),
    .count_x_i (count_x_i),
    .count_y_i (count_y_i),
    .step_o    (step),
    .row_end_o (row_end),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  assign tile_base[0] = pat_base_i;
  assign tile_base[1] = src_base_i;
  assign tile_off[0]  = pat_off_i;
  assign tile_off[1]  = src_off_i;
  assign tile_wrap[0] = pat_wrap_i;
  assign tile_wrap[1] = src_wrap_i;

  for (genvar g = 0; g < NUM_TILE; g++) begin : g_tile
    blit_tile_walker #(
      .ADDR_W (ADDR_W),
      .OFF_W  (OFF_W),
      .ALIGN  ((g == 0) ? 1'b1 : 1'b0)
    ) u_walk (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (start_i),
      .step_i    (step),
      .row_end_i (row_end),
      .x_dec_i   (dir_q[0]),
      .y_dec_i   (dir_q[1]),
      .base_i    (tile_base[g]),
      .off_i     (tile_off[g]),
      .wrap_i    (tile_wrap[g]),
      .addr_o    (tile_addr[g])
    );
  end

  blit_dest_walker #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_dest (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (start_i),
    .step_i    (step),
    .row_end_i (row_end),
    .x_dec_i   (dir_q[0]),
    .y_dec_i   (dir_q[1]),
    .base_i    (dst_base_i),
    .off_i     (dst_off_i),
    .addr_o    (dst_addr_o)
  );

  assign pat_addr_o = tile_addr[0];
  assign src_addr_o = tile_addr[1];

endmodule

// File: rtl/blit_addr_walker_chk.sv
module blit_addr_walker_chk #(
  parameter int ADDR_W = 21
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              enable_i,
  input logic              busy_i,
  input logic              done_i,
  input logic              x_dec_i,
  input logic              row_end_i,
  input logic [ADDR_W-1:0] dst_base_i,
  input logic [ADDR_W-1:0] pat_addr_i,
  input logic [ADDR_W-1:0] src_addr_i,
  input logic [ADDR_W-1:0] dst_addr_i
);

  assert_start_loads_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_i && (dst_addr_i == $past(dst_base_i)));

  assert_done_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  assert_done_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> !busy_i);

  assert_busy_fall_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> done_i);

  assert_stall_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !enable_i && !start_i) |=>
      busy_i && $stable(dst_addr_i) && $stable(pat_addr_i) && $stable(src_addr_i));

  assert_dst_byte_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && enable_i && !start_i && !row_end_i) |=>
      dst_addr_i == ($past(x_dec_i) ? ($past(dst_addr_i) - ADDR_W'(1))
                                    : ($past(dst_addr_i) + ADDR_W'(1))));

endmodule

bind blit_addr_walker blit_addr_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .enable_i   (enable_i),
  .busy_i     (busy_o),
  .done_i     (done_o),
  .x_dec_i    (dir_q[0]),
  .row_end_i  (row_end),
  .dst_base_i (dst_base_i),
  .pat_addr_i (pat_addr_o),
  .src_addr_i (src_addr_o),
  .dst_addr_i (dst_addr_o)
);

// File: tb/blit_addr_walker_tb.sv
module blit_addr_walker_tb;

  localparam int AW = 12;
  localparam int OW = 8;
  localparam int CW = 8;
  localparam int M  = (1 << AW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          enable = 1'b1;
  logic [1:0]    dir = 2'b00;
  logic [AW-1:0] pb = '0, sb = '0, db = '0;
  logic [OW-1:0] po = '0, so = '0, dof = '0;
  logic [7:0]    pw = '0, sw = '0;
  logic [CW-1:0] cx = '0, cy = '0;
  logic [AW-1:0] pat_a, src_a, dst_a;
  logic          busy, done;

  int    n_chk = 0, n_bad = 0;
  bit    gap_mode = 1'b0;
  bit    exp_done = 1'b0;
  bit    finished = 1'b0;
  string cur_req = "R2";
  logic [3*AW-1:0] exp_q[$];

  always #10 clk = ~clk;

  blit_addr_walker #(.ADDR_W(AW), .OFF_W(OW), .CNT_W(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .enable_i(enable), .dir_i(dir),
    .pat_base_i(pb), .src_base_i(sb), .dst_base_i(db),
    .pat_off_i(po), .src_off_i(so), .dst_off_i(dof),
    .pat_wrap_i(pw), .src_wrap_i(sw), .count_x_i(cx), .count_y_i(cy),
    .pat_addr_o(pat_a), .src_addr_o(src_a), .dst_addr_o(dst_a),
    .busy_o(busy), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int xmask_of(input int code);
    if (code == 7) return M;
    if (code < 2)  return 0;
    return (1 << code) - 1;
  endfunction

  // Reference walk built from the requirements
  task automatic build_expect(input int p_b, input int s_b, input int d_b,
                              input int p_o, input int s_o, input int d_o,
                              input int dr, input int p_w, input int s_w,
                              input int c_x, input int c_y);
    int pxm = xmask_of(p_w & 7);
    int sxm = xmask_of(s_w & 7);
    bit pyo = p_w[6];
    bit syo = s_w[6];
    int pyl = (p_w >> 4) & 3;
    int syl = (s_w >> 4) & 3;
    int px0 = p_b & pxm;
    int pbase = p_b & ~pxm & M;
    int py = 0, sy = 0, sx = 0, px, phome, sbase, dcur, drow, pa, sa;
    if (!p_w[7] && (p_w & 7) != 7 && !pyo) begin
      int xl = ((p_w & 7) < 2) ? 0 : (p_w & 7);
      py    = (pbase >> xl) & ((1 << pyl) - 1);
      pbase = pbase & ~((1 << (xl + pyl)) - 1) & M;
    end
    phome = pbase; px = px0; sbase = s_b; dcur = d_b; drow = d_b;
    for (int r = 0; r <= c_y; r++) begin
      for (int c = 0; c <= c_x; c++) begin
        pa = (dr[0] ? (pbase - px) : (pbase + px)) & M;
        sa = (dr[0] ? (sbase - sx) : (sbase + sx)) & M;
        exp_q.push_back({AW'(pa), AW'(sa), AW'(dcur)});
        if (c < c_x) begin
          px   = (px + 1) & pxm;
          sx   = (sx + 1) & sxm;
          dcur = (dr[0] ? dcur - 1 : dcur + 1) & M;
        end else begin
          if (!pyo && py == (1 << pyl) - 1) begin pbase = phome; py = 0; end
          else begin pbase = (dr[1] ? pbase - (p_o + 1) : pbase + (p_o + 1)) & M; py++; end
          if (!syo && sy == (1 << syl) - 1) begin sbase = s_b; sy = 0; end
          else begin sbase = (dr[1] ? sbase - (s_o + 1) : sbase + (s_o + 1)) & M; sy++; end
          px   = px0;
          sx   = 0;
          drow = (dr[1] ? drow - (d_o + 1) : drow + (d_o + 1)) & M;
          dcur = drow;
        end
      end
    end
  endtask

  task automatic launch(input string req, input int p_b, input int s_b, input int d_b,
                        input int p_o, input int s_o, input int d_o, input int dr,
                        input int p_w, input int s_w, input int c_x, input int c_y);
    @(posedge clk); #1;
    exp_q.delete();
    cur_req = req;
    build_expect(p_b, s_b, d_b, p_o, s_o, d_o, dr, p_w, s_w, c_x, c_y);
    pb = AW'(p_b); sb = AW'(s_b); db = AW'(d_b);
    po = OW'(p_o); so = OW'(s_o); dof = OW'(d_o);
    dir = 2'(dr); pw = 8'(p_w); sw = 8'(s_w); cx = CW'(c_x); cy = CW'(c_y);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic finish_blit();
    wait (exp_q.size() == 0);
    repeat (3) @(negedge clk);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (exp_done) begin
        chk(done && !busy, "R3", "done pulse after final step", {busy, done}, 2'b01);
        exp_done = 1'b0;
      end else if (done) begin
        chk(1'b0, "R3", "unexpected done", done, 0);
      end
      if (busy && !start) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3", "busy past rectangle", busy, 0);
        end else begin
          chk({pat_a, src_a, dst_a} == exp_q[0], enable ? cur_req : "R4",
              enable ? "address triple" : "held address triple",
              {pat_a, src_a, dst_a}, exp_q[0]);
          if (enable) begin
            void'(exp_q.pop_front());
            if (exp_q.size() == 0) exp_done = 1'b1;
          end
        end
      end else if (!busy && !start && exp_q.size() != 0) begin
        chk(1'b0, "R3", "busy dropped early", exp_q.size(), 0);
      end
    end
  end

  always @(posedge clk) begin
    #1;
    enable = gap_mode ? ($urandom_range(0, 2) != 0) : 1'b1;
  end

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=expired expected=complete");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R1", "flags after reset", {busy, done}, 0);
    chk(dst_a == 0 && pat_a == 0 && src_a == 0, "R1", "addresses after reset",
        {pat_a, src_a, dst_a}, 0);

    // R2 R7: plain forward walk, no tiles
    launch("R7", 'h100, 'h200, 'h300, 'h10, 'h20, 'h3F, 0, 'hC7, 'hC7, 3, 2);
    finish_blit();
    // R5: X decrement
    launch("R5", 'h100, 'h200, 'h310, 'h10, 'h20, 'h3F, 1, 'hC7, 'hC7, 3, 2);
    finish_blit();
    // R6: Y decrement
    launch("R6", 'h500, 'h600, 'h700, 'h10, 'h08, 'h3F, 2, 'hC7, 'hC7, 2, 3);
    finish_blit();
    // R11: both decrement from near zero, wraps to top of space
    launch("R11", 'h003, 'h001, 'h002, 'h04, 'h04, 'h04, 3, 'hC7, 'hC7, 4, 2);
    finish_blit();
    // R8: X masks 3 and 7, then codes 0 and 1
    launch("R8", 'h400, 'h800, 'h900, 'h20, 'h20, 'h20, 0, 'hC2, 'hC3, 9, 1);
    finish_blit();
    launch("R8", 'h404, 'h808, 'h900, 'h20, 'h20, 'h20, 0, 'hC0, 'hC1, 5, 1);
    finish_blit();
    // R9: Y tile of 2 rows on pattern, 4 rows on source
    launch("R9", 'h140, 'h240, 'h340, 'h0F, 'h0F, 'h0F, 0, 'h97, 'h27, 2, 6);
    finish_blit();
    // R10: aligned pattern tile, then the same with alignment skipped
    launch("R10", 'h135, 'h240, 'h340, 'h03, 'h0F, 'h0F, 0, 'h12, 'hC7, 5, 3);
    finish_blit();
    launch("R10", 'h135, 'h240, 'h340, 'h03, 'h0F, 'h0F, 0, 'h92, 'hC7, 5, 3);
    finish_blit();
    // R4: random stalls on a tiled, reversed walk
    gap_mode = 1'b1;
    launch("R4", 'h235, 'hA40, 'hB40, 'h07, 'h05, 'h1F, 1, 'h23, 'h14, 6, 5);
    finish_blit();
    gap_mode = 1'b0;
    // R12: restart while busy
    launch("R12", 'h100, 'h200, 'h300, 'h10, 'h10, 'h10, 0, 'hC7, 'hC7, 7, 7);
    repeat (4) @(negedge clk);
    launch("R12", 'h050, 'h060, 'h070, 'h02, 'h02, 'h02, 0, 'hC7, 'hC7, 1, 1);
    finish_blit();
    chk(!busy && !done, "R3", "idle after final rectangle", {busy, done}, 0);
    report();
  end

endmodule